// File: doc/BRIEF.md
# Accumulator and Multiplier-Quotient Shift Unit

This block holds a sign-magnitude accumulator and a multiplier-quotient register. The accumulator is 38 bits wide: a sign, two guard positions named Q and P that sit above the magnitude, and a 35-bit magnitude. Bit 1 is the most significant magnitude bit and bit 35 is the least significant. The multiplier-quotient register has a sign and a 35-bit magnitude with the same bit order. The block gives a sequencer the basic steps that multiply, divide and normalize routines are built from. It can load either register, add an operand's magnitude into the accumulator, and shift the accumulator, the multiplier-quotient register, or the two joined into one long register. It keeps a sticky overflow flag, which a separate input clears.

Commands arrive on a valid/ready channel. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a multi-cycle shift is running, `cmd_ready` is low. A sender that has `cmd_valid` high must hold the op, data and count fields stable until the command is accepted. Every accepted command ends with a one-cycle `done` pulse. The register contents are visible at all times on `ac_out` and `mq_out`. The overflow flag `ovf` and its clear input `ovf_clr` are plain control pins.

Top module: `acmq_unit`

## Requirements
- R1: After reset, `ac_out`, `mq_out` and `ovf` are all zero, `cmd_ready` is high and `done` is low.
- R2: Op 0 loads the accumulator: the sign comes from `cmd_data[35]`, the magnitude from `cmd_data[34:0]`, and Q and P are cleared. Op 1 loads the multiplier-quotient register from all 36 bits of `cmd_data`.
- R3: Op 2 adds `cmd_data[34:0]` to the 37-bit field {Q,P,magnitude} of the accumulator. The accumulator sign and `cmd_data[35]` play no part. A carry out of Q is discarded.
- R4: During op 2, a carry out of magnitude bit 1 into P sets `ovf`.
- R5: Op 3 shifts the accumulator field {Q,P,magnitude} left with a 0 entering bit 35, and the bit leaving Q is lost. Op 4 shifts it right with a 0 entering Q, and the bit leaving bit 35 is lost. The multiplier-quotient register is unchanged, and no sign ever moves during any shift.
- R6: Op 5 shifts the multiplier-quotient magnitude left and op 6 shifts it right, each with zero fill. The accumulator is unchanged.
- R7: Op 7 shifts the 72-bit chain {Q,P,AC magnitude,MQ magnitude} left, with MQ bit 1 entering AC bit 35. Op 8 shifts the same chain right, with AC bit 35 entering MQ bit 1. Zeros fill both ends.
- R8: Every left-shift step (ops 3 and 7) that moves a 1 from AC bit 1 into P sets `ovf`.
- R9: `ovf` stays set until an edge where `ovf_clr` is high. If an overflow event happens on that same edge, the flag stays set.
- R10: A shift with count N > 0 (`cmd_count`, 8 bits) does one step per clock. `cmd_ready` is low while it runs, and `done` is high in the cycle after the N-th step. Loads, adds, unused op codes (9 to 15) and shifts with count 0 pulse `done` in the cycle after acceptance. A shift with count 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_op | input | 4 | Operation code (0 to 8) |
| cmd_data | input | 36 | Operand, sign in bit 35 |
| cmd_count | input | 8 | Shift step count |
| ovf_clr | input | 1 | Clear the overflow flag |
| done | output | 1 | One-cycle completion pulse |
| ac_out | output | 38 | {sign, Q, P, magnitude bits 1..35} |
| mq_out | output | 36 | {sign, magnitude bits 1..35} |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions check on every cycle that:
- the overflow flag holds until cleared and rises only after an accepted command or a running shift step;
- both signs stay put while a shift runs;
- `cmd_ready` drops after a shift with a non-zero count is accepted;
- the step counter never ends a shift early.

Only the bench's scenarios can show that the data moves correctly: the bit positions after each shift variant, the crossing bits between the two registers in long shifts, Q and P wrapping on an add, and the priority of a set over a clear on the same edge. The bench shows these by comparing the outputs against a model of the full 72-bit chain.

// File: rtl/acmq_pkg.sv
package acmq_pkg;
  typedef enum logic [3:0] {
    OP_LOAD_AC  = 4'd0,
    OP_LOAD_MQ  = 4'd1,
    OP_ADD_MAG  = 4'd2,
    OP_SHL_AC   = 4'd3,
    OP_SHR_AC   = 4'd4,
    OP_SHL_MQ   = 4'd5,
    OP_SHR_MQ   = 4'd6,
    OP_SHL_LONG = 4'd7,
    OP_SHR_LONG = 4'd8
  } acmq_op_e;

  function automatic logic op_is_shift(input acmq_op_e op);
    return (op == OP_SHL_AC) || (op == OP_SHR_AC) || (op == OP_SHL_MQ) ||
           (op == OP_SHR_MQ) || (op == OP_SHL_LONG) || (op == OP_SHR_LONG);
  endfunction
endpackage

// File: rtl/acmq_mag_add.sv
module acmq_mag_add #(
  parameter int MAG_W = 35
) (
  input  logic [MAG_W+1:0] acx_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic [MAG_W+1:0] acx_o,
  output logic             carry_p
);
  logic [MAG_W:0] mag_sum;
  logic [1:0]     guard;

  always_comb begin
    mag_sum = {1'b0, acx_i[MAG_W-1:0]} + {1'b0, mag_i};
    carry_p = mag_sum[MAG_W];
    guard   = acx_i[MAG_W+1:MAG_W] + {1'b0, carry_p};
    acx_o   = {guard, mag_sum[MAG_W-1:0]};
  end
endmodule

// File: rtl/acmq_shift_step.sv
module acmq_shift_step
  import acmq_pkg::*;
#(
  parameter int MAG_W = 35
) (
  input  acmq_op_e         op,
  input  logic [MAG_W+1:0] acx_i,
  input  logic [MAG_W-1:0] mq_i,
  output logic [MAG_W+1:0] acx_o,
  output logic [MAG_W-1:0] mq_o,
  output logic             ovf_evt
);
  logic fill_lo;

  always_comb begin
    acx_o   = acx_i;
    mq_o    = mq_i;
    ovf_evt = 1'b0;
    fill_lo = (op == OP_SHL_LONG) ? mq_i[MAG_W-1] : 1'b0;
    case (op)
      OP_SHL_AC, OP_SHL_LONG: begin
        acx_o   = {acx_i[MAG_W:0], fill_lo};
        ovf_evt = acx_i[MAG_W-1];
      end
      OP_SHR_AC, OP_SHR_LONG: acx_o = {1'b0, acx_i[MAG_W+1:1]};
      default: ;
    endcase
    case (op)
      OP_SHL_MQ, OP_SHL_LONG: mq_o = {mq_i[MAG_W-2:0], 1'b0};
      OP_SHR_MQ:              mq_o = {1'b0, mq_i[MAG_W-1:1]};
      OP_SHR_LONG:            mq_o = {acx_i[0], mq_i[MAG_W-1:1]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acmq_step_ctrl.sv
module acmq_step_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_shift,
  input  logic [CNT_W-1:0] start_count,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      remaining <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (start_shift && (start_count != '0)) begin
          busy      <= 1'b1;
          remaining <= start_count;
        end else begin
          done <= 1'b1;
        end
      end else if (busy) begin
        remaining <= remaining - 1'b1;
        if (remaining == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10
  early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (remaining != CNT_W'(1)) |=> busy && !done);
endmodule

// File: rtl/acmq_unit.sv
module acmq_unit
  import acmq_pkg::*;
#(
  parameter int MAG_W = 35,
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [3:0]         cmd_op,
  input  logic [MAG_W:0]     cmd_data,
  input  logic [CNT_W-1:0]   cmd_count,
  input  logic               ovf_clr,
  output logic               done,
  output logic [MAG_W+2:0]   ac_out,
  output logic [MAG_W:0]     mq_out,
  output logic               ovf
);
  localparam int ACX_W = MAG_W + 2;

  acmq_op_e         op_in, op_q;
  logic             accept, busy;
  logic             ac_sign, mq_sign;
  logic [ACX_W-1:0] acx, acx_sum, acx_step;
  logic [MAG_W-1:0] mq_mag, mq_step;
  logic             add_carry, step_evt, ovf_set;

  assign op_in     = acmq_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;

  acmq_step_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(accept),
    .start_shift(op_is_shift(op_in)), .start_count(cmd_count),
    .busy(busy), .done(done)
  );

  acmq_mag_add #(.MAG_W(MAG_W)) u_add (
    .acx_i(acx), .mag_i(cmd_data[MAG_W-1:0]),
    .acx_o(acx_sum), .carry_p(add_carry)
  );

  acmq_shift_step #(.MAG_W(MAG_W)) u_step (
    .op(op_q), .acx_i(acx), .mq_i(mq_mag),
    .acx_o(acx_step), .mq_o(mq_step), .ovf_evt(step_evt)
  );

  assign ovf_set = (accept && (op_in == OP_ADD_MAG) && add_carry) ||
                   (busy && step_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q    <= OP_LOAD_AC;
      ac_sign <= 1'b0;
      mq_sign <= 1'b0;
      acx     <= '0;
      mq_mag  <= '0;
      ovf     <= 1'b0;
    end else begin
      ovf <= (ovf && !ovf_clr) || ovf_set;
      if (accept) begin
        op_q <= op_in;
        case (op_in)
          OP_LOAD_AC: begin
            ac_sign <= cmd_data[MAG_W];
            acx     <= {2'b00, cmd_data[MAG_W-1:0]};
          end
          OP_LOAD_MQ: begin
            mq_sign <= cmd_data[MAG_W];
            mq_mag  <= cmd_data[MAG_W-1:0];
          end
          OP_ADD_MAG: acx <= acx_sum;
          default: ;
        endcase
      end else if (busy) begin
        acx    <= acx_step;
        mq_mag <= mq_step;
      end
    end
  end

  assign ac_out = {ac_sign, acx};
  assign mq_out = {mq_sign, mq_mag};

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);

  // R4
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf ##1 ovf |-> $past(busy) || $past(accept));

  // R5
  sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ac_sign) && $stable(mq_sign));

  // R10
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_is_shift(op_in) && (cmd_count != '0) |=> !cmd_ready);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

// File: tb/acmq_unit_bench.sv
module acmq_unit_bench;
  localparam int MAG = 35;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [3:0]  cmd_op = '0;
  logic [35:0] cmd_data = '0;
  logic [7:0]  cmd_count = '0;
  logic        ovf_clr = 1'b0;
  logic        done;
  logic [37:0] ac_out;
  logic [35:0] mq_out;
  logic        ovf;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [37:0] ac;
    logic [35:0] mq;
    logic        fl;
    string       req;
  } exp_t;
  exp_t sb[$];

  logic [36:0] m_acx = '0;
  logic [34:0] m_mq = '0;
  logic        m_acs = 1'b0, m_mqs = 1'b0, m_ovf = 1'b0;

  always #10 clk = ~clk;

  acmq_unit u_acmq_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_count(cmd_count),
    .ovf_clr(ovf_clr), .done(done), .ac_out(ac_out), .mq_out(mq_out), .ovf(ovf)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Monitor: pop expected item at each done pulse.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R10", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "ac_out", 64'(ac_out), 64'(e.ac));
        check(e.req, "mq_out", 64'(mq_out), 64'(e.mq));
        check(e.req, "ovf", 64'(ovf), 64'(e.fl));
      end
    end
  end

  // Independent model of one command per the requirements.
  task automatic model(input int op, input logic [35:0] d, input int cnt, input logic clr);
    logic [71:0] chain;
    logic [35:0] msum;
    if (clr) m_ovf = 1'b0;
    case (op)
      0: begin m_acs = d[35]; m_acx = {2'b00, d[34:0]}; end
      1: begin m_mqs = d[35]; m_mq = d[34:0]; end
      2: begin
        msum = {1'b0, m_acx[34:0]} + {1'b0, d[34:0]};
        m_acx[36:35] = m_acx[36:35] + {1'b0, msum[35]};
        m_acx[34:0]  = msum[34:0];
        if (msum[35]) m_ovf = 1'b1;
      end
      default: begin
        for (int i = 0; i < cnt; i++) begin
          chain = {m_acx, m_mq};
          case (op)
            3: begin if (m_acx[34]) m_ovf = 1'b1; m_acx = m_acx << 1; end
            4: m_acx = m_acx >> 1;
            5: m_mq = m_mq << 1;
            6: m_mq = m_mq >> 1;
            7: begin if (m_acx[34]) m_ovf = 1'b1; chain = chain << 1;
                     {m_acx, m_mq} = chain; end
            8: begin chain = chain >> 1; {m_acx, m_mq} = chain; end
            default: ;
          endcase
        end
      end
    endcase
  endtask

  // Driver: issue command, push expectation, wait for completion.
  task automatic issue(input int op, input logic [35:0] d, input int cnt,
                       input logic clr, input string req);
    exp_t e;
    model(op, d, cnt, clr);
    e.ac = {m_acs, m_acx}; e.mq = {m_mqs, m_mq}; e.fl = m_ovf; e.req = req;
    sb.push_back(e);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_data = d; cmd_count = 8'(cnt);
    ovf_clr = clr;
    @(negedge clk);
    cmd_valid = 1'b0; ovf_clr = 1'b0;
    if (op >= 3 && op <= 8 && cnt > 0)
      check("R10", "ready low while shifting", 64'(cmd_ready), 64'd0);
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ac_out", 64'(ac_out), 64'd0);
    check("R1", "mq_out", 64'(mq_out), 64'd0);
    check("R1", "ovf", 64'(ovf), 64'd0);
    check("R1", "cmd_ready", 64'(cmd_ready), 64'd1);
    check("R1", "done", 64'(done), 64'd0);

    // R2 loads
    issue(0, {1'b1, 35'h2_3456_789A}, 0, 1'b0, "R2");
    issue(1, {1'b1, 35'h5_5555_5555}, 0, 1'b0, "R2");
    // R3 add without carry, sign of operand ignored
    issue(2, {1'b1, 35'h0_0000_1234}, 0, 1'b0, "R3");
    // R4 add with carry into P
    issue(0, {1'b0, {35{1'b1}}}, 0, 1'b0, "R2");
    issue(2, 36'd1, 0, 1'b0, "R4");
    // R9 explicit clear with no command
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R9", "ovf after clear", 64'(ovf), 64'd0);
    m_ovf = 1'b0;
    // R9 clear and set on the same edge: set wins
    issue(0, {1'b0, {35{1'b1}}}, 0, 1'b0, "R2");
    issue(2, 36'd5, 0, 1'b1, "R9");
    m_ovf = 1'b0;
    ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    // R8 / R5 left AC shift with bit 1 set, Q drop
    issue(0, {1'b1, 35'h6_0000_0001}, 0, 1'b0, "R2");
    issue(3, 36'd0, 3, 1'b0, "R8");
    // R3 Q,P wrap on add
    issue(0, {1'b0, {35{1'b1}}}, 0, 1'b0, "R2");
    issue(3, 36'd0, 2, 1'b0, "R5");
    issue(2, 36'd7, 0, 1'b0, "R3");
    // R5 right AC shift
    issue(4, 36'd0, 5, 1'b0, "R5");
    // R6 MQ-only shifts
    issue(1, {1'b0, 35'h4_0F0F_0F0F}, 0, 1'b0, "R2");
    issue(5, 36'd0, 4, 1'b0, "R6");
    issue(6, 36'd0, 9, 1'b0, "R6");
    // R7 long shifts across the boundary
    issue(0, {1'b1, 35'h0_0000_0003}, 0, 1'b0, "R2");
    issue(1, {1'b0, 35'h7_0000_0000}, 0, 1'b0, "R2");
    issue(7, 36'd0, 6, 1'b0, "R7");
    issue(8, 36'd0, 40, 1'b0, "R7");
    issue(7, 36'd0, 80, 1'b1, "R7");
    // R10 zero-count shift changes nothing; unused op completes
    issue(0, {1'b0, 35'h1_2345_6789}, 0, 1'b0, "R2");
    issue(3, 36'd0, 0, 1'b0, "R10");
    issue(12, 36'hF_FFFF_FFFF, 0, 1'b0, "R10");
    issue(8, 36'd0, 1, 1'b0, "R10");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule